// File: doc/BRIEF.md
# DSP-Framed Stereo Audio Sample Receiver

This block takes the serial ADC output of an audio codec and turns it into one parallel stereo word for each sample period. The codec is the clock master. It drives the bit clock and a one-bit-clock-wide frame sync pulse, and it sends each frame as a left 16-bit two's complement sample followed by a right 16-bit sample. Both samples are sent MSB first. The nominal frame rate is 48 kHz.

All three codec lines pass through two-flop synchronizers into the system clock domain. Bits are taken on the detected rising edge of the bit clock. When a frame has been fully received, the 32-bit word is published in a single update and a full flag rises in the same cycle. A polling microcontroller reads the word while the flag is high. It then pulses an acknowledge, or it lets the next frame's sync pulse clear the flag.

Top module: `pcm_frame_rx`

## Requirements
- R1: While reset is high, `frame_o` is zero and `full_o` is low.
- R2: After a bit clock rising edge with the frame sync high, the next 32 rising edges each shift in one data bit, MSB first. The first bit becomes `frame_o[31]`. The left sample lands in `frame_o[31:16]` and the right sample in `frame_o[15:0]`.
- R3: `full_o` rises in the same cycle that `frame_o` takes a new value, and only after all 32 bits of a frame have been received.
- R4: A one-cycle `rd_ack_i` pulse while `full_o` is high clears `full_o` on the next cycle and leaves `frame_o` unchanged.
- R5: A frame sync seen on a bit clock rising edge clears `full_o` if it is still set. `frame_o` keeps the previous frame until the new frame completes.
- R6: A frame sync that arrives partway through a frame restarts the capture. The partial bits are discarded, and `full_o` does not rise for the aborted frame.
- R7: Bit clock rising edges after the 32nd bit and before the next frame sync change neither `frame_o` nor `full_o`.
- R8: When the bit clock does not toggle, changes on the frame sync and data lines change neither `frame_o` nor `full_o`.
- R9: Asserting reset partway through a frame discards the partial frame and returns both outputs to their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Bit clock driven by the codec |
| fsync_i | input | 1 | Frame sync pulse driven by the codec |
| sdata_i | input | 1 | Serial ADC data driven by the codec |
| rd_ack_i | input | 1 | One-cycle read acknowledge from the consumer |
| frame_o | output | 32 | Captured frame: left sample in [31:16], right sample in [15:0] |
| full_o | output | 1 | High while an unread complete frame is held |

## Verification
A bit clock rise reaches the block's registers after three system clock edges: two synchronizer stages and one shift stage. The output register takes the finished word, and sets or clears the flag, on the fourth edge. The bench holds each bit clock level for five system cycles and samples on falling edges of the system clock. Because of that, every frame, sync and no-effect check is taken only after the last bit clock rise has fully propagated. Acknowledge checks are sampled on the falling edge that follows the cycle in which the pulse was registered.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

    localparam int DEF_SAMPLE_W    = 16;
    localparam int DEF_SYNC_STAGES = 2;

    // Synchronized codec pins, carried together through the front end
    typedef struct packed {
        logic bclk;
        logic fsync;
        logic sdata;
    } codec_pins_t;

    localparam int PIN_W = $bits(codec_pins_t);

    typedef enum logic {
        RX_IDLE  = 1'b0,
        RX_SHIFT = 1'b1
    } rx_state_t;

    function automatic logic is_rise(input logic cur, input logic prev);
        return cur & ~prev;
    endfunction

endpackage

// File: rtl/pcm_sync.sv
module pcm_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= '0;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pcm_deser.sv
module pcm_deser
    import pcm_rx_pkg::*;
#(
    parameter int FRAME_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  codec_pins_t        pins,
    output logic               start_p,
    output logic               done_p,
    output logic [FRAME_W-1:0] word
);
    localparam int CNT_W = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

    rx_state_t          state;
    logic [CNT_W-1:0]   bit_cnt;
    logic [FRAME_W-1:0] shreg;
    logic               bclk_d;
    logic               bclk_rise;
    logic [FRAME_W-1:0] shreg_nxt;

    assign bclk_rise = is_rise(pins.bclk, bclk_d);
    assign shreg_nxt = {shreg[FRAME_W-2:0], pins.sdata};

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RX_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            bclk_d  <= 1'b0;
            start_p <= 1'b0;
            done_p  <= 1'b0;
            word    <= '0;
        end else begin
            bclk_d  <= pins.bclk;
            start_p <= 1'b0;
            done_p  <= 1'b0;
            if (bclk_rise) begin
                if (pins.fsync) begin
                    // sync pulse: the next rise carries the MSB of the left sample
                    state   <= RX_SHIFT;
                    bit_cnt <= '0;
                    start_p <= 1'b1;
                end else if (state == RX_SHIFT) begin
                    shreg <= shreg_nxt;
                    if (bit_cnt == LAST_BIT) begin
                        word    <= shreg_nxt;
                        done_p  <= 1'b1;
                        state   <= RX_IDLE;
                        bit_cnt <= '0;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/pcm_hold.sv
module pcm_hold #(
    parameter int FRAME_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_p,
    input  logic               done_p,
    input  logic               ack,
    input  logic [FRAME_W-1:0] word_in,
    output logic [FRAME_W-1:0] word_out,
    output logic               full
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word_out <= '0;
            full     <= 1'b0;
        end else if (done_p) begin
            word_out <= word_in;
            full     <= 1'b1;
        end else if (start_p || ack) begin
            full     <= 1'b0;
        end
    end
endmodule

// File: rtl/pcm_frame_rx.sv
module pcm_frame_rx
    import pcm_rx_pkg::*;
#(
    parameter int SAMPLE_W    = DEF_SAMPLE_W,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bclk_i,
    input  logic                  fsync_i,
    input  logic                  sdata_i,
    input  logic                  rd_ack_i,
    output logic [2*SAMPLE_W-1:0] frame_o,
    output logic                  full_o
);
    localparam int FRAME_W = 2 * SAMPLE_W;

    codec_pins_t        pins_raw;
    codec_pins_t        pins_s;
    logic               start_p;
    logic               done_p;
    logic [FRAME_W-1:0] word;

    assign pins_raw = '{bclk: bclk_i, fsync: fsync_i, sdata: sdata_i};

    pcm_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_s)
    );

    pcm_deser #(.FRAME_W(FRAME_W)) u_deser (
        .clk     (clk),
        .rst     (rst),
        .pins    (pins_s),
        .start_p (start_p),
        .done_p  (done_p),
        .word    (word)
    );

    pcm_hold #(.FRAME_W(FRAME_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .start_p  (start_p),
        .done_p   (done_p),
        .ack      (rd_ack_i),
        .word_in  (word),
        .word_out (frame_o),
        .full     (full_o)
    );
endmodule

// File: rtl/pcm_frame_rx_chk.sv
module pcm_frame_rx_chk #(
    parameter int FRAME_W = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               rd_ack_i,
    input logic               start_p,
    input logic               done_p,
    input logic [FRAME_W-1:0] frame_o,
    input logic               full_o
);
    // R1: outputs are cleared whenever reset is held
    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (frame_o == '0 && !full_o));

    // R3: the flag rises only on a completed frame
    p_full_from_done_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(full_o) |-> $past(done_p));

    // R3: a completed frame always raises the flag
    p_done_sets_full_r3: assert property (@(posedge clk) disable iff (rst)
        done_p |=> full_o);

    // R3, R7: the word changes only one cycle after a completed frame
    p_word_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !done_p |=> $stable(frame_o));

    // R4: acknowledge clears the flag and keeps the word
    p_ack_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_ack_i && full_o && !done_p) |=> (!full_o && $stable(frame_o)));

    // R5: a new frame start clears the flag
    p_start_clears_r5: assert property (@(posedge clk) disable iff (rst)
        start_p |=> !full_o);

    // R6: a start and a completion never coincide
    p_start_done_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(start_p && done_p));
endmodule

bind pcm_frame_rx pcm_frame_rx_chk #(.FRAME_W(FRAME_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_ack_i (rd_ack_i),
    .start_p  (start_p),
    .done_p   (done_p),
    .frame_o  (frame_o),
    .full_o   (full_o)
);

// File: tb/pcm_frame_rx_test.sv
module pcm_frame_rx_test;

    localparam int HALF_BCLK = 5;
    localparam int NVEC      = 6;
    localparam logic [31:0] VEC [NVEC] = '{
        32'h8000_7FFF, 32'hFFFF_0000, 32'h0000_0000,
        32'hA5A5_5A5A, 32'h1234_ABCD, 32'h0001_8000
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bclk = 1'b0, fsync = 1'b0, sdata = 1'b0, ack = 1'b0;
    logic [31:0] frame;
    logic        full;
    int          n_chk = 0, n_bad = 0, cyc = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    pcm_frame_rx uut (
        .clk      (clk),
        .rst      (rst),
        .bclk_i   (bclk),
        .fsync_i  (fsync),
        .sdata_i  (sdata),
        .rd_ack_i (ack),
        .frame_o  (frame),
        .full_o   (full)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bit_cycle(input logic fs, input logic d);
        @(negedge clk);
        bclk = 1'b0; fsync = fs; sdata = d;
        repeat (HALF_BCLK) @(negedge clk);
        bclk = 1'b1;
        repeat (HALF_BCLK) @(negedge clk);
    endtask

    task automatic send_bits(input logic [31:0] w, input int n);
        for (int i = 0; i < n; i++) bit_cycle(1'b0, w[31-i]);
    endtask

    task automatic send_frame(input logic [31:0] w);
        bit_cycle(1'b1, 1'b0);
        send_bits(w, 32);
    endtask

    task automatic pulse_ack();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_bad++;
                $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
                $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 reset word", frame, 32'h0);
        chk("R1 reset flag", {31'h0, full}, 32'h0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R2, R3, R4: table of frames
        for (int i = 0; i < NVEC; i++) begin
            send_frame(VEC[i]);
            chk("R2 frame word", frame, VEC[i]);
            chk("R3 flag set", {31'h0, full}, 32'h1);
            pulse_ack();
            chk("R4 ack clears flag", {31'h0, full}, 32'h0);
            chk("R4 ack keeps word", frame, VEC[i]);
        end

        // R3: flag stays low while a frame is partly received
        bit_cycle(1'b1, 1'b0);
        send_bits(32'hFFFF_FFFF, 31);
        chk("R3 no flag before 32nd bit", {31'h0, full}, 32'h0);
        chk("R3 word held before 32nd bit", frame, VEC[NVEC-1]);
        send_bits(32'h0000_0000, 1);
        chk("R3 flag after 32nd bit", {31'h0, full}, 32'h1);
        chk("R2 word after 32nd bit", frame, 32'hFFFF_FFFE);
        pulse_ack();

        // R6: sync mid-frame restarts capture
        bit_cycle(1'b1, 1'b0);
        send_bits(32'hFFFF_FFFF, 10);
        chk("R6 no flag for partial", {31'h0, full}, 32'h0);
        send_frame(32'h5A5A_C3C3);
        chk("R6 restarted word", frame, 32'h5A5A_C3C3);
        chk("R6 restarted flag", {31'h0, full}, 32'h1);

        // R7: extra bits after the frame are ignored
        send_bits(32'hFFFF_FFFF, 6);
        chk("R7 extra bits word", frame, 32'h5A5A_C3C3);
        chk("R7 extra bits flag", {31'h0, full}, 32'h1);

        // R8: no bit clock edges, other lines toggling
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            fsync = k[0]; sdata = k[1];
        end
        fsync = 1'b0;
        repeat (6) @(negedge clk);
        chk("R8 static bclk word", frame, 32'h5A5A_C3C3);
        chk("R8 static bclk flag", {31'h0, full}, 32'h1);

        // R5: next frame sync clears an unread flag
        bit_cycle(1'b1, 1'b0);
        chk("R5 sync clears flag", {31'h0, full}, 32'h0);
        chk("R5 sync keeps word", frame, 32'h5A5A_C3C3);
        send_bits(32'h0F0F_F0F0, 32);
        chk("R5 following frame word", frame, 32'h0F0F_F0F0);

        // R9: reset mid-frame
        bit_cycle(1'b1, 1'b0);
        send_bits(32'hFFFF_FFFF, 8);
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 reset word", frame, 32'h0);
        chk("R9 reset flag", {31'h0, full}, 32'h0);
        rst = 1'b0;
        send_bits(32'hFFFF_FFFF, 24);
        chk("R9 partial discarded", {31'h0, full}, 32'h0);
        send_frame(32'hCAFE_0123);
        chk("R9 capture after reset", frame, 32'hCAFE_0123);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule